// File: doc/BRIEF.md
# Three-wire codec control bus master

This block drives a three-wire serial control bus (clock, data and mode lines) of the kind used to program the registers of audio codecs. A host hands it one command: a 6-bit device address, a 2-bit register-type selector, a byte count and a read/write flag. The block then sends an address byte followed by one or more data bytes, or clocks data bytes back in. All bus timing is counted in system clocks through module parameters: clock-low time, clock-high time, mode setup, mode hold and the halt gap.

The address byte is `{dev, sel}` (the device address in bits 7:2 and the selector in bits 1:0). It goes out with mode low. Data bytes follow with mode high. Every byte travels least significant bit first. The first data byte follows the address phase directly. Every later data byte is preceded by a halt pulse on the clock line. On a read, the block stops driving the data line once the address byte is done.

The streaming sides follow valid/ready rules. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle. Write bytes are taken on `wr_valid && wr_ready`. `wr_ready` rises only when the block needs the next byte, and the bus clock stays high until that byte arrives. Read bytes are offered on `rd_valid`. `rd_valid` and `rd_data` hold until `rd_ready`, and the bus stays paused meanwhile.

Top module: `tri_wire_ctl_master`

## Requirements
- R1: The address byte equals `(cmd_dev << 2) | cmd_sel`. It is sent LSB first while `bus_mode` is 0, and `bus_oe` is high from the first cycle of the transaction.
- R2: Write data bytes are sent LSB first while `bus_mode` is 1, in the order they arrive on the write stream. A bit's value is the level on the data line when the bus clock rises.
- R3: For every bit, the bus clock is low for T_LOW cycles and then high for T_HIGH cycles. Before the first address bit the clock is also low for T_SETUP cycles, so that bit's low time is T_SETUP+T_LOW.
- R4: Every data byte except the first is preceded by a halt pulse: the clock low for T_HALT cycles, then high. A transfer of N data bytes has N-1 halt pulses, and a one-byte transfer has none.
- R5: `bus_mode` stays low for T_HIGH+T_HOLD cycles after the last rising clock edge of the address byte. The clock then stays high for at least T_SETUP cycles after `bus_mode` rises, before the first data bit. Mode changes only while the clock is high.
- R6: On a read, `bus_data_oe` is low from the end of the address phase to the end of the transaction. Each bit is sampled in the last clock-low cycle, and the bytes are returned on the read stream in bus order.
- R7: When a transaction ends, `busy`, `bus_oe` and `bus_data_oe` are low, and `done` pulses for exactly one cycle, in the first cycle in which `busy` is low.
- R8: `cmd_ready` is low while `busy` is high. A command presented while busy is ignored and starts no bus activity.
- R9: `wr_ready` is high only while the block waits for the next write byte, and the bus clock is held high for the whole wait.
- R10: `rd_valid` stays high with `rd_data` unchanged until `rd_ready` is seen, and the bus clock is held high meanwhile.
- R11: After reset, `busy`, `done`, `bus_oe`, `bus_data_oe`, `wr_ready` and `rd_valid` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid is high (idle only) |
| cmd_dev | input | 6 | Device address, placed in address byte bits 7:2 |
| cmd_sel | input | 2 | Register-type selector, placed in address byte bits 1:0 |
| cmd_rd | input | 1 | 1 = read transaction, 0 = write |
| cmd_cnt_m1 | input | LEN_W | Number of data bytes minus one |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block waits for the next write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host accepts the read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| bus_clk | output | 1 | Bus clock line level |
| bus_mode | output | 1 | Bus mode line level (0 address, 1 data) |
| bus_oe | output | 1 | Output enable for the clock and mode lines |
| bus_data_o | output | 1 | Data line level when driven |
| bus_data_oe | output | 1 | Data line output enable |
| bus_data_i | input | 1 | Data line level as seen on the pin |

## Verification
The assertions assume that `rd_ready` and `wr_valid` are ordinary handshake inputs. They also assume the host changes no command fields mid-transaction in a way that matters, since fields are read only in the accepting cycle. The mode-edge and clock-hold checks rely on the bus line enables going high together at the start. The stimulus drives every input on the falling system clock edge. It uses counts from 1 up to the parameter maximum, and it presents extra commands only while a transaction is running. For reads, the attached slave model changes its data bit only after a rising bus clock, so the value sampled in the last clock-low cycle is always stable.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LO,
    ST_HI,
    ST_HOLD,
    ST_FETCH,
    ST_HALT,
    ST_SETUP,
    ST_PUSH
  } tw_state_e;

  function automatic int tw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          expired
);

  logic [CW-1:0] cnt;

  assign expired = (cnt == (lim - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tw_shift.sv
module tw_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       shift,
  input  logic       sin,
  input  logic       tick,
  output logic [7:0] q,
  output logic       last
);

  logic [2:0] bit_cnt;

  assign last = (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      q       <= load_val;
      bit_cnt <= '0;
    end else begin
      if (shift) q <= {sin, q[7:1]};
      if (tick)  bit_cnt <= bit_cnt + 3'd1;
    end
  end

endmodule

// File: rtl/tri_wire_ctl_master.sv
module tri_wire_ctl_master
  import tw_pkg::*;
#(
  parameter int T_LOW     = 3,
  parameter int T_HIGH    = 3,
  parameter int T_SETUP   = 2,
  parameter int T_HOLD    = 2,
  parameter int T_HALT    = 5,
  parameter int MAX_BYTES = 4,
  localparam int LEN_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [5:0]       cmd_dev,
  input  logic [1:0]       cmd_sel,
  input  logic             cmd_rd,
  input  logic [LEN_W-1:0] cmd_cnt_m1,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             bus_clk,
  output logic             bus_mode,
  output logic             bus_oe,
  output logic             bus_data_o,
  output logic             bus_data_oe,
  input  logic             bus_data_i
);

  localparam int TMAX = tw_max(tw_max(tw_max(T_LOW, T_HIGH), tw_max(T_SETUP, T_HOLD)), T_HALT);
  localparam int CW   = $clog2(TMAX + 1);

  tw_state_e        state, nxt;
  logic             rd_q, addr_ph, done_q;
  logic [LEN_W-1:0] cnt_m1, bidx;

  logic             accept, fin, byte_adv;
  logic             sh_load, sh_shift, tick;
  logic [7:0]       sh_val, sh_q;
  logic             bit_last, t_exp, drv;
  logic [CW-1:0]    lim;
  logic             last_byte;

  assign drv       = addr_ph || !rd_q;
  assign last_byte = (bidx == cnt_m1);
  assign sh_val    = accept ? {cmd_dev, cmd_sel} : wr_data;

  // duration of the current timed state
  always_comb begin
    unique case (state)
      ST_LEAD, ST_SETUP: lim = CW'(T_SETUP);
      ST_LO:             lim = CW'(T_LOW);
      ST_HI:             lim = CW'(T_HIGH);
      ST_HOLD:           lim = CW'(T_HOLD);
      ST_HALT:           lim = CW'(T_HALT);
      default:           lim = CW'(1);
    endcase
  end

  tw_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (nxt != state),
    .lim     (lim),
    .expired (t_exp)
  );

  tw_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (sh_shift),
    .sin      (bus_data_i),
    .tick     (tick),
    .q        (sh_q),
    .last     (bit_last)
  );

  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    fin      = 1'b0;
    byte_adv = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    tick     = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_valid) begin
        nxt     = ST_LEAD;
        accept  = 1'b1;
        sh_load = 1'b1;
      end
      ST_LEAD: if (t_exp) nxt = ST_LO;
      ST_LO: if (t_exp) begin
        nxt      = ST_HI;
        sh_shift = !drv;          // read sample at end of clock low
      end
      ST_HI: if (t_exp) begin
        tick     = 1'b1;
        sh_shift = drv;           // next output bit after the rising edge
        nxt      = bit_last ? ST_HOLD : ST_LO;
      end
      ST_HOLD: if (t_exp) begin
        if (addr_ph)        nxt = rd_q ? ST_SETUP : ST_FETCH;
        else if (rd_q)      nxt = ST_PUSH;
        else if (last_byte) begin
          nxt = ST_IDLE;
          fin = 1'b1;
        end else begin
          nxt      = ST_FETCH;
          byte_adv = 1'b1;
        end
      end
      ST_FETCH: if (wr_valid) begin
        sh_load = 1'b1;
        nxt     = (bidx != '0) ? ST_HALT : ST_SETUP;
      end
      ST_HALT:  if (t_exp) nxt = ST_SETUP;
      ST_SETUP: if (t_exp) nxt = ST_LO;
      ST_PUSH: if (rd_ready) begin
        if (last_byte) begin
          nxt = ST_IDLE;
          fin = 1'b1;
        end else begin
          nxt      = ST_HALT;
          byte_adv = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rd_q    <= 1'b0;
      addr_ph <= 1'b0;
      cnt_m1  <= '0;
      bidx    <= '0;
      done_q  <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= fin;
      if (accept) begin
        rd_q    <= cmd_rd;
        addr_ph <= 1'b1;
        cnt_m1  <= cmd_cnt_m1;
        bidx    <= '0;
      end else begin
        if (state == ST_HOLD && t_exp && addr_ph) addr_ph <= 1'b0;
        if (byte_adv) bidx <= bidx + 1'b1;
      end
    end
  end

  assign busy        = (state != ST_IDLE);
  assign cmd_ready   = (state == ST_IDLE);
  assign done        = done_q;
  assign wr_ready    = (state == ST_FETCH);
  assign rd_valid    = (state == ST_PUSH);
  assign rd_data     = sh_q;
  assign bus_oe      = busy;
  assign bus_clk     = !(state == ST_LEAD || state == ST_LO || state == ST_HALT);
  assign bus_mode    = busy ? !addr_ph : 1'b1;
  assign bus_data_o  = sh_q[0];
  assign bus_data_oe = busy && drv;

endmodule

// File: rtl/tw_master_chk.sv
module tw_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       cmd_ready,
  input logic       bus_oe,
  input logic       bus_data_oe,
  input logic       bus_clk,
  input logic       bus_mode,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       wr_ready
);

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_oe && !bus_data_oe)); // R7

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R8

  AST_DATA_OE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> bus_oe); // R6

  AST_MODE_EDGE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe) && !$stable(bus_mode)) |-> bus_clk); // R5

  AST_FETCH_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (bus_clk && bus_oe)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && bus_clk)); // R10

endmodule

bind tri_wire_ctl_master tw_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .cmd_ready   (cmd_ready),
  .bus_oe      (bus_oe),
  .bus_data_oe (bus_data_oe),
  .bus_clk     (bus_clk),
  .bus_mode    (bus_mode),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .wr_ready    (wr_ready)
);

// File: tb/tri_wire_ctl_master_tb.sv
`timescale 1ns/100ps
module tri_wire_ctl_master_tb;

  localparam int T_LOW = 3, T_HIGH = 3, T_SETUP = 2, T_HOLD = 2, T_HALT = 5;
  localparam int MAXB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_rd = 1'b0;
  logic [5:0] cmd_dev = '0;
  logic [1:0] cmd_sel = '0;
  logic [1:0] cmd_cnt_m1 = '0;
  logic wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic busy, done, bus_clk, bus_mode, bus_oe, bus_data_o, bus_data_oe, bus_data_i;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  tri_wire_ctl_master #(
    .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD),
    .T_HALT(T_HALT), .MAX_BYTES(MAXB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dev(cmd_dev), .cmd_sel(cmd_sel),
    .cmd_rd(cmd_rd), .cmd_cnt_m1(cmd_cnt_m1),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done),
    .bus_clk(bus_clk), .bus_mode(bus_mode), .bus_oe(bus_oe),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i)
  );

  // ---------------- bus monitor and slave model ----------------
  logic [7:0] tx_byte [MAXB];
  logic [7:0] sl_byte [MAXB];
  logic [7:0] got_rd  [MAXB];
  logic [7:0] mon_byte [8];
  logic [7:0] mon_addr;
  int mon_abit, mon_bidx, mon_bit, mon_halts, mon_lowbad, mon_highbad;
  int mon_gap, mon_su, mon_oebad;
  int gap, su, lo_run, hi_run;
  bit su_act;
  logic p_clk = 1'b1, p_oe = 1'b0, p_mode = 1'b1;
  bit cur_rd;

  initial begin
    mon_addr = '0; mon_abit = 0; mon_bidx = 0; mon_bit = 0; mon_halts = 0;
    mon_lowbad = 0; mon_highbad = 0; mon_gap = 0; mon_su = 0; mon_oebad = 0;
    gap = 0; su = 0; su_act = 0; lo_run = 0; hi_run = 0; cur_rd = 0;
    for (int i = 0; i < 8; i++) mon_byte[i] = '0;
    for (int i = 0; i < MAXB; i++) begin tx_byte[i] = '0; sl_byte[i] = '0; got_rd[i] = '0; end
  end

  assign bus_data_i = (mon_bidx < MAXB) ? sl_byte[mon_bidx[1:0]][mon_bit[2:0]] : 1'b0;

  always @(negedge clk) begin
    logic v;
    if (bus_oe && !p_oe) begin
      mon_addr = '0; mon_abit = 0; mon_bidx = 0; mon_bit = 0; mon_halts = 0;
      mon_lowbad = 0; mon_highbad = 0; mon_gap = 0; mon_su = 0; mon_oebad = 0;
      gap = 0; su = 0; su_act = 0;
      for (int i = 0; i < 8; i++) mon_byte[i] = '0;
    end
    if (bus_oe) begin
      v = bus_data_oe ? bus_data_o : bus_data_i;
      if (bus_mode && bus_data_oe && cur_rd) mon_oebad++;
      if (bus_clk && !p_clk) begin
        if (!bus_mode) begin
          if (mon_abit == 0 && lo_run != T_SETUP + T_LOW) mon_lowbad++;
          else if (mon_abit != 0 && lo_run != T_LOW) mon_lowbad++;
          if (mon_abit < 8) mon_addr[mon_abit] = v;
          mon_abit++;
          gap = 1;
        end else if (lo_run == T_HALT) begin
          mon_halts++;
        end else begin
          if (lo_run != T_LOW) mon_lowbad++;
          if (mon_bidx < 8) mon_byte[mon_bidx][mon_bit] = v;
          mon_bit++;
          if (mon_bit == 8) begin mon_bit = 0; mon_bidx++; end
        end
      end else if (!bus_mode && bus_clk) begin
        gap++;
      end
      if (!bus_clk && p_clk && p_oe) begin
        if ((!bus_mode && mon_abit >= 1 && mon_abit <= 7) || (bus_mode && mon_bit >= 1))
          if (hi_run != T_HIGH) mon_highbad++;
      end
      if (bus_mode && !p_mode && p_oe) begin
        mon_gap = gap; su = 1; su_act = 1;
      end else if (su_act) begin
        if (bus_clk) su++;
        else begin mon_su = su; su_act = 0; end
      end
    end
    lo_run = bus_clk ? 0 : lo_run + 1;
    hi_run = bus_clk ? hi_run + 1 : 0;
    p_clk = bus_clk; p_oe = bus_oe; p_mode = bus_mode;
  end

  // ---------------- helpers ----------------
  task automatic check_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_ge(input string req, input string what, input int act, input int lo);
    total++;
    if (act < lo) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lo);
    end
  endtask

  int done_cnt, done_bad, stall_seen, stall_clk_bad, ready_bad, bp_clk_bad;

  task automatic run_txn(input logic [5:0] dev, input logic [1:0] sel, input bit rd,
                         input int n, input int stall, input bit bp, input bit hold_cmd);
    int wi = 0, ri = 0, cyc = 0, st = stall;
    done_cnt = 0; done_bad = 0; stall_seen = 0; stall_clk_bad = 0;
    ready_bad = 0; bp_clk_bad = 0;
    cur_rd = rd;
    for (int i = 0; i < MAXB; i++) got_rd[i] = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dev = dev; cmd_sel = sel; cmd_rd = rd;
    cmd_cnt_m1 = 2'(n - 1);
    @(negedge clk);
    if (hold_cmd) begin
      cmd_dev = ~dev; cmd_rd = ~rd; cmd_cnt_m1 = 2'd0;
    end else begin
      cmd_valid = 1'b0;
    end
    while (cyc < 5000) begin
      if (done) begin
        done_cnt++;
        if (busy || bus_oe || bus_data_oe) done_bad++;
      end
      if (!busy) break;
      if (cmd_ready) ready_bad++;
      if (!rd && wi < n) begin
        if (st > 0 && wr_ready) begin
          st--; stall_seen++;
          wr_valid = 1'b0;
          if (!bus_clk) stall_clk_bad++;
        end else if (st == 0) begin
          wr_valid = 1'b1; wr_data = tx_byte[wi];
        end
        if (wr_valid && wr_ready) wi++;
      end else begin
        wr_valid = 1'b0;
      end
      if (rd) begin
        rd_ready = bp ? ((cyc % 3) == 0) : 1'b1;
        if (rd_valid && !rd_ready && !bus_clk) bp_clk_bad++;
        if (rd_valid && rd_ready && ri < MAXB) begin got_rd[ri] = rd_data; ri++; end
      end
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0;
    if (cyc >= 5000) check_eq("R7", "transaction did not finish", cyc, 0);
  endtask

  task automatic check_common(input logic [5:0] dev, input logic [1:0] sel, input int n);
    check_eq("R1", "address byte", int'(mon_addr), int'({dev, sel}));
    check_eq("R1", "address bit count", mon_abit, 8);
    check_eq("R4", "halt pulses", mon_halts, n - 1);
    check_eq("R3", "bits with wrong low time", mon_lowbad, 0);
    check_eq("R3", "bits with wrong high time", mon_highbad, 0);
    check_eq("R5", "mode low after last address edge", mon_gap, T_HIGH + T_HOLD);
    check_ge("R5", "clock high after mode rise", mon_su, T_SETUP);
    check_eq("R7", "done pulses", done_cnt, 1);
    check_eq("R7", "done while lines driven", done_bad, 0);
    check_eq("R7", "bus_oe after end", int'(bus_oe), 0);
    check_eq("R7", "bus_data_oe after end", int'(bus_data_oe), 0);
    check_eq("R8", "cmd_ready while busy", ready_bad, 0);
    check_eq("R2", "data bytes seen on bus", mon_bidx, n);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check_eq("R11", "busy", int'(busy), 0);
    check_eq("R11", "done", int'(done), 0);
    check_eq("R11", "bus_oe", int'(bus_oe), 0);
    check_eq("R11", "bus_data_oe", int'(bus_data_oe), 0);
    check_eq("R11", "wr_ready", int'(wr_ready), 0);
    check_eq("R11", "rd_valid", int'(rd_valid), 0);
    check_eq("R11", "cmd_ready", int'(cmd_ready), 1);
  endtask

  task automatic t_write_one();
    tx_byte[0] = 8'hA7;
    run_txn(6'h05, 2'b10, 1'b0, 1, 0, 1'b0, 1'b0);
    check_common(6'h05, 2'b10, 1);
    check_eq("R2", "single write byte", int'(mon_byte[0]), 8'hA7);
    check_eq("R4", "no halt on one-byte transfer", mon_halts, 0);
  endtask

  task automatic t_write_three_stall();
    tx_byte[0] = 8'h3C; tx_byte[1] = 8'h81; tx_byte[2] = 8'hFE;
    run_txn(6'h2A, 2'b01, 1'b0, 3, 4, 1'b0, 1'b0);
    check_common(6'h2A, 2'b01, 3);
    for (int i = 0; i < 3; i++)
      check_eq("R2", "write byte in order", int'(mon_byte[i]), int'(tx_byte[i]));
    check_eq("R9", "stall cycles with wr_ready", stall_seen, 4);
    check_eq("R9", "clock low during write wait", stall_clk_bad, 0);
  endtask

  task automatic t_read(input int n, input bit bp);
    sl_byte[0] = 8'h5A; sl_byte[1] = 8'hC3; sl_byte[2] = 8'h0F; sl_byte[3] = 8'h96;
    run_txn(6'h11, 2'b00, 1'b1, n, 0, bp, 1'b0);
    check_common(6'h11, 2'b00, n);
    check_eq("R5", "read setup exact", mon_su, T_SETUP);
    check_eq("R6", "data driven during read phase", mon_oebad, 0);
    for (int i = 0; i < n; i++)
      check_eq("R6", "read byte returned", int'(got_rd[i]), int'(sl_byte[i]));
    check_eq("R10", "clock low while read byte waits", bp_clk_bad, 0);
  endtask

  task automatic t_busy_ignore();
    int act = 0;
    tx_byte[0] = 8'h12; tx_byte[1] = 8'h34;
    run_txn(6'h3F, 2'b11, 1'b0, 2, 0, 1'b0, 1'b1);
    check_common(6'h3F, 2'b11, 2);
    check_eq("R2", "first byte under busy command", int'(mon_byte[0]), 8'h12);
    check_eq("R2", "second byte under busy command", int'(mon_byte[1]), 8'h34);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_oe || busy) act++;
    end
    check_eq("R8", "activity from command given while busy", act, 0);
  endtask

  initial begin
    #500_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_one();
    t_write_three_stall();
    t_read(2, 1'b1);
    t_read(4, 1'b0);
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule